// File: doc/BRIEF.md
# Repeating Loop Code Generator

This block turns a short programmable code into an endless serial bit stream for in-band loopback signalling on a T1-rate line. Software loads a 16-bit code as two bytes, picks a code length of 1 to 8 or 16 bits, and sets a send control. While sending is allowed, the block emits one code bit on each line-clock enable, most significant bit first, starting from the top bit of the first byte. While sending is not allowed, the line payload passes through unchanged.

A framing strobe marks the framing-bit slot of each 193-bit frame. In that slot the framing bit normally replaces the code bit. A keep option leaves the code bit in that slot instead. The code position moves on through the slot either way, so the overwrite never shifts the code's phase. Any change to the length or to either code byte, and every new start of sending, sends the code again from its first bit.

Top module: `loopcode_gen`

## Requirements
- R1: After reset, `data_out` is 0 and the code position is at bit 7 of `pat_first`.
- R2: `len_sel` picks the code length: 0→5, 1→6, 2→7, 3→8, 4→16, 5→4, 6→3, 7→2, 8→1, and any code from 9 to 15 →16.
- R3: For lengths 3, 5, 6 and 7, the stream repeats the top L bits of `pat_first`, MSB first, every L bits. `pat_second` is not used.
- R4: For lengths 1, 2, 4, 8 and 16, the stream cycles through the 16-bit word {`pat_first`,`pat_second`}, MSB first, every 16 bits. Both bytes are therefore sent.
- R5: Generation is on only while `tx_en` and `t1_mode` are both 1. Otherwise each `bit_en` cycle registers `payload_in` onto `data_out`.
- R6: On the first `bit_en` after generation turns on, the bit sent is bit 7 of `pat_first`.
- R7: When `len_sel`, `pat_first` or `pat_second` changes while generation is on, the next bit sent is bit 7 of the new `pat_first`.
- R8: On a `bit_en` cycle with `fslot`=1 and `fbit_keep`=0, `fbit_val` is sent in place of the code bit, and the code position still advances.
- R9: With `fbit_keep`=1, `fslot` has no effect and the code bit is sent.
- R10: `data_out` changes only at a clock edge where `bit_en` is 1. `payload_in`, `fslot` and `fbit_val` are ignored in other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t1_mode | input | 1 | Line runs at T1 rate; generation is allowed |
| tx_en | input | 1 | Send the loop code |
| len_sel | input | 4 | Code length select |
| pat_first | input | 8 | First code byte, sent from its MSB |
| pat_second | input | 8 | Second code byte |
| bit_en | input | 1 | One line bit per asserted cycle |
| fslot | input | 1 | Current bit is the framing-bit slot |
| fbit_val | input | 1 | Framing bit value for the slot |
| fbit_keep | input | 1 | Do not overwrite the framing slot |
| payload_in | input | 1 | Line payload used while not generating |
| data_out | output | 1 | Serial line bit |

## Verification
The bench sweeps every length code, including the codes above 8, with two code bytes that differ. A design that wrapped short codes at 8 or 16 bits, or that ignored the second byte for the lengths that divide 16, sends the wrong bit within one code period. It changes the code and the length in the middle of a stream. A design that lacks the restart carries on from its old position and sends the wrong first bit. It runs streams of several frames with the framing slot placed where the framing bit differs from the code bit, both with and without the keep option. A design that stalls the code position in the slot shows a phase slip on every later bit. Empty cycles between bits catch any output that changes without an enable.

// File: rtl/loopcode_gen.sv
module loopcode_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       t1_mode,
  input  logic       tx_en,
  input  logic [3:0] len_sel,
  input  logic [7:0] pat_first,
  input  logic [7:0] pat_second,
  input  logic       bit_en,
  input  logic       fslot,
  input  logic       fbit_val,
  input  logic       fbit_keep,
  input  logic       payload_in,
  output logic       data_out
);
  logic        gen_on, en_q, restart, short_len, pat_bit;
  logic [19:0] cfg, cfg_q;
  logic [15:0] word;
  logic [4:0]  plen;
  logic [3:0]  ptr, cur, last;

  assign gen_on = tx_en & t1_mode;
  assign cfg    = {len_sel, pat_first, pat_second};
  assign word   = {pat_first, pat_second};

  always_comb begin
    case (len_sel)
      4'd0:    plen = 5'd5;
      4'd1:    plen = 5'd6;
      4'd2:    plen = 5'd7;
      4'd3:    plen = 5'd8;
      4'd5:    plen = 5'd4;
      4'd6:    plen = 5'd3;
      4'd7:    plen = 5'd2;
      4'd8:    plen = 5'd1;
      default: plen = 5'd16;
    endcase
  end

  assign short_len = (plen == 5'd3) | (plen == 5'd5) | (plen == 5'd6) | (plen == 5'd7);
  assign last      = short_len ? plen[3:0] - 4'd1 : 4'd15;
  assign restart   = gen_on & (~en_q | (cfg != cfg_q));
  assign cur       = restart ? 4'd0 : ptr;
  assign pat_bit   = word[4'd15 - cur];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      cfg_q    <= '0;
      ptr      <= '0;
      data_out <= 1'b0;
    end else begin
      en_q  <= gen_on;
      cfg_q <= cfg;
      if (!gen_on)
        ptr <= '0;
      else if (bit_en)
        ptr <= (cur == last) ? 4'd0 : cur + 4'd1;
      else
        ptr <= cur;
      if (bit_en)
        data_out <= !gen_on ? payload_in :
                    (fslot & ~fbit_keep) ? fbit_val : pat_bit;
    end
  end
endmodule

// File: rtl/loopcode_gen_chk.sv
module loopcode_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       t1_mode,
  input logic       tx_en,
  input logic [3:0] len_sel,
  input logic [7:0] pat_first,
  input logic [7:0] pat_second,
  input logic       bit_en,
  input logic       fslot,
  input logic       fbit_val,
  input logic       fbit_keep,
  input logic       payload_in,
  input logic       data_out
);
  logic prev_on;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_on <= 1'b0;
    else        prev_on <= tx_en & t1_mode;
  end

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && !(tx_en && t1_mode) |=> data_out == $past(payload_in)); // R5
  AST_FSLOT_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && tx_en && t1_mode && fslot && !fbit_keep |=> data_out == $past(fbit_val)); // R8
  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(data_out)); // R10
  AST_START_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && tx_en && t1_mode && !prev_on && !(fslot && !fbit_keep)
    |=> data_out == $past(pat_first[7])); // R6
endmodule

bind loopcode_gen loopcode_gen_chk chk_i (.*);

// File: tb/loopcode_gen_tb_top.sv
module loopcode_gen_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, t1_mode, tx_en, bit_en, fslot, fbit_val, fbit_keep, payload_in, data_out;
  logic [3:0] len_sel;
  logic [7:0] pat_first, pat_second;

  loopcode_gen dut_i (.*);

  int    checks = 0, errors = 0;
  bit    done = 0;
  logic  exp_q[$];
  string req_q[$];
  logic  last_exp = 1'b0;

  function automatic int len_of(input logic [3:0] c);
    case (c)
      4'd0: return 5; 4'd1: return 6; 4'd2: return 7; 4'd3: return 8;
      4'd5: return 4; 4'd6: return 3; 4'd7: return 2; 4'd8: return 1;
      default: return 16;
    endcase
  endfunction

  function automatic logic pat_bit(input logic [7:0] hi, input logic [7:0] lo,
                                   input logic [3:0] c, input int k);
    logic [15:0] w;
    int l, wrap;
    w = {hi, lo};
    l = len_of(c);
    wrap = (l == 3 || l == 5 || l == 6 || l == 7) ? l : 16;
    return w[15 - (k % wrap)];
  endfunction

  // monitor: pop one expectation per clock edge
  always @(posedge clk) begin
    logic  e;
    string r;
    if (exp_q.size() > 0) begin
      #1;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if (data_out !== e) begin
        errors++;
        $display("FAIL %s data_out=%b expected=%b at %0t", r, data_out, e, $time);
      end
    end
  end

  // driver: called at a falling edge, sets inputs, pushes expectation
  task automatic drive(input logic be, input logic fs, input logic fv, input logic pl,
                       input logic ex, input string r);
    bit_en = be; fslot = fs; fbit_val = fv; payload_in = pl;
    exp_q.push_back(ex); req_q.push_back(r); last_exp = ex;
    @(negedge clk);
  endtask

  task automatic run_pattern(input logic [7:0] hi, input logic [7:0] lo, input logic [3:0] c,
                             input int n, input bit toggle, input logic fkeep,
                             input bit fs_on, input string req);
    logic fs, fv, ex;
    string r;
    if (toggle) begin
      tx_en = 1'b0;
      drive(1'b0, 1'b0, 1'b0, 1'b0, last_exp, "R10");
    end
    tx_en = 1'b1; t1_mode = 1'b1;
    pat_first = hi; pat_second = lo; len_sel = c; fbit_keep = fkeep;
    for (int k = 0; k < n; k++) begin
      if (k % 5 == 3) drive(1'b0, 1'b1, 1'b1, 1'b1, last_exp, "R10");
      fs = fs_on && (k % 193 == 10);
      fv = ((k / 193) % 2) != 0;
      ex = (fs && !fkeep) ? fv : pat_bit(hi, lo, c, k);
      r  = (k == 0) ? (toggle ? "R6" : "R7") : (fs ? (fkeep ? "R9" : "R8") : req);
      drive(1'b1, fs, fv, logic'(k % 2 == 0), ex, r);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; t1_mode = 1'b0; tx_en = 1'b0; bit_en = 1'b0; fslot = 1'b0;
    fbit_val = 1'b0; fbit_keep = 1'b0; payload_in = 1'b0;
    len_sel = '0; pat_first = '0; pat_second = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (data_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 data_out=%b expected=0", data_out);
    end

    // R5: pass-through while disabled, then with t1_mode low
    for (int k = 0; k < 12; k++)
      drive(1'b1, 1'b0, 1'b0, logic'((k * 3) % 4 == 1), logic'((k * 3) % 4 == 1), "R5");
    tx_en = 1'b1; t1_mode = 1'b0;
    for (int k = 0; k < 12; k++)
      drive(1'b1, logic'(k % 2), 1'b1, logic'(k % 3 == 0), logic'(k % 3 == 0), "R5");
    drive(1'b0, 1'b0, 1'b0, ~last_exp, last_exp, "R10");

    // R1/R6: first bit after start comes from the top of the first byte
    run_pattern(8'h80, 8'h00, 4'd0, 20, 1'b1, 1'b0, 1'b0, "R3");

    // R2/R3/R4: every length code
    for (int c = 0; c < 16; c++)
      run_pattern(8'hB5, 8'h3C, 4'(c), 40, 1'b1, 1'b0, 1'b0,
                  (len_of(4'(c)) inside {3, 5, 6, 7}) ? "R3" : ((c > 8) ? "R2" : "R4"));

    // R7: rewrite code byte, then length, mid-stream
    run_pattern(8'hA5, 8'h0F, 4'd3, 11, 1'b1, 1'b0, 1'b0, "R4");
    run_pattern(8'h3C, 8'h0F, 4'd3, 12, 1'b0, 1'b0, 1'b0, "R4");
    run_pattern(8'h3C, 8'h0F, 4'd0, 12, 1'b0, 1'b0, 1'b0, "R3");
    run_pattern(8'h3C, 8'hF0, 4'd4, 20, 1'b0, 1'b0, 1'b0, "R4");

    // R8/R9: framing slot across several frames
    run_pattern(8'h80, 8'h00, 4'd0, 400, 1'b1, 1'b0, 1'b1, "R8");
    run_pattern(8'h80, 8'h00, 4'd0, 400, 1'b1, 1'b1, 1'b1, "R9");

    tx_en = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, last_exp, "R10");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule